// File: doc/BRIEF.md
# LCD Controller Command Sequencer

This block produces the command byte streams that bring up and steer a 240x160 grayscale LCD controller over a byte-wide serial command path. It does three jobs, and each is started by a one-cycle request pulse:

- A power-up configuration sequence. It is built from small configuration inputs: bias ratio, bias gain, bias potentiometer, temperature coefficient, panel load and charge-pump mode.
- A single blank or unblank command.
- Rotation-dependent commands. One request sends the RAM addressing mode and the panel mirroring. A second request sends a four-byte window address taken from the window start coordinates.

Bytes leave on a valid/ready handshake together with a command/data flag. A separate shifter turns this stream into serial traffic.

The block latches its inputs when it accepts a request: the rotation, the configuration fields and the coordinates. A busy output covers the whole sequence. Requests that arrive while busy is high are dropped. When several requests arrive in the same cycle, a fixed priority picks one of them.

Top module: `lcd_cmd_seq`

## Requirements
- R1: An init request sends ten bytes in this order: 0xE2; 0xE8|ratio; 0x81; {gain[1:0], pot[5:0]}; 0x24|temp; 0x28|load; 0x2C|pump; 0xA7; 0xD2; 0xAF.
- R2: A blank request sends the single byte 0xA8. An unblank request sends the single byte 0xAF.
- R3: A mode request sends two bytes. The first is the addressing byte 0x88|(pageFirst<<1)|1. Rotation is coded 0=0°, 1=90°, 2=180°, 3=270°, and pageFirst is set for codes 1 and 3.
- R4: The second mode byte is the mapping byte 0xC0|(mirrorY<<2)|(mirrorX<<1). Code 0 sets mirrorX only, code 1 sets neither, code 2 sets mirrorY only, and code 3 sets both.
- R5: A window request sends four bytes: col[3:0]; 0x10|(col>>4); 0x60|row[4:1]; 0x70|(row>>5).
- R6: For rotation codes 0 and 2, col is xStart and row is yStart. For codes 1 and 3 the two are swapped.
- R7: Every byte leaves with the command/data flag low.
- R8: While a byte is valid and not ready, the byte stays valid and unchanged. A byte advances only on a valid-and-ready cycle.
- R9: Busy rises in the cycle after an accepted request and falls in the cycle after the last byte is accepted. Valid is never high while busy is low.
- R10: Requests that arrive while busy are ignored. Changes to the rotation, configuration or coordinate inputs during a sequence have no effect on it.
- R11: When requests arrive in the same cycle, the priority is init, then blank, then unblank, then mode, then window.
- R12: During and after reset the block is idle, with valid low and busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| initReq | input | 1 | Start the configuration sequence |
| blankReq | input | 1 | Send the blank command |
| unblankReq | input | 1 | Send the unblank command |
| modeReq | input | 1 | Send the addressing mode and mirroring bytes |
| windowReq | input | 1 | Send the window address bytes |
| rotSel | input | 2 | Rotation code (0/90/180/270) |
| ratioIn | input | 2 | Bias ratio field |
| gainIn | input | 2 | Bias gain field |
| potIn | input | 6 | Bias potentiometer field |
| tempIn | input | 2 | Temperature compensation field |
| loadIn | input | 2 | Panel load field |
| pumpIn | input | 2 | Pump mode field |
| xStart | input | 8 | Window start column in screen coordinates |
| yStart | input | 8 | Window start row in screen coordinates |
| outData | output | 8 | Command byte |
| outValid | output | 1 | Byte valid |
| outReady | input | 1 | Sink accepts the byte |
| outIsData | output | 1 | Command/data flag (low = command) |
| busy | output | 1 | A sequence is in progress |

## Verification
The configuration sequence is run with two different sets of fields, so a field routed to the wrong opcode or bit slot changes at least one byte. Mode requests are sent for all four rotation codes, which separates the page-first bit from the two mirror bits. Window requests use coordinates whose high and low nibbles differ, and they are sent in each rotation, so a missing axis swap or a wrong shift is caught. Directed cases cover the remaining rules: a sink that is held not-ready, requests and input changes while busy, and simultaneous requests.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  localparam int COORD_W = 8;
  localparam int IDX_W   = 4;

  typedef enum logic [2:0] {
    JOB_INIT    = 3'd0,
    JOB_BLANK   = 3'd1,
    JOB_UNBLANK = 3'd2,
    JOB_MODE    = 3'd3,
    JOB_WINDOW  = 3'd4
  } seqJob_t;

  typedef struct packed {
    logic [1:0] ratio;
    logic [1:0] gain;
    logic [5:0] pot;
    logic [1:0] temp;
    logic [1:0] load;
    logic [1:0] pump;
  } biasCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             active;
    logic             load;
    seqJob_t          job;
    logic [IDX_W-1:0] idx;
  } ctrlStrobe_t;

  function automatic logic [IDX_W-1:0] lastIdx(seqJob_t job);
    case (job)
      JOB_INIT:   return IDX_W'(9);
      JOB_MODE:   return IDX_W'(1);
      JOB_WINDOW: return IDX_W'(3);
      default:    return IDX_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        initReq,
  input  logic        blankReq,
  input  logic        unblankReq,
  input  logic        modeReq,
  input  logic        windowReq,
  input  logic        outReady,
  output ctrlStrobe_t strobe,
  output logic        outValid,
  output logic        busy
);

  logic             activeQ;
  logic [IDX_W-1:0] idxQ;
  seqJob_t          jobQ;
  seqJob_t          pickJob;
  logic             anyReq;
  logic             fire;
  logic             lastByte;

  // fixed priority among simultaneous requests
  always_comb begin
    anyReq  = initReq | blankReq | unblankReq | modeReq | windowReq;
    if (initReq)         pickJob = JOB_INIT;
    else if (blankReq)   pickJob = JOB_BLANK;
    else if (unblankReq) pickJob = JOB_UNBLANK;
    else if (modeReq)    pickJob = JOB_MODE;
    else                 pickJob = JOB_WINDOW;
  end

  assign fire     = activeQ & outReady;
  assign lastByte = (idxQ == lastIdx(jobQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      idxQ    <= '0;
      jobQ    <= JOB_INIT;
    end else if (!activeQ) begin
      if (anyReq) begin
        activeQ <= 1'b1;
        idxQ    <= '0;
        jobQ    <= pickJob;
      end
    end else if (fire) begin
      if (lastByte) activeQ <= 1'b0;
      else          idxQ    <= idxQ + 1'b1;
    end
  end

  always_comb begin
    strobe.active = activeQ;
    strobe.load   = !activeQ && anyReq;
    strobe.job    = strobe.load ? pickJob : jobQ;
    strobe.idx    = idxQ;
  end

  assign outValid = activeQ;
  assign busy     = activeQ;

  // R10
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    activeQ && !outReady |=> activeQ && $stable(idxQ) && $stable(jobQ));

  // R9
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    activeQ && !lastByte |=> activeQ);

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    activeQ |-> idxQ <= lastIdx(jobQ));

  // R11
  init_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    !activeQ && initReq |=> activeQ && jobQ == JOB_INIT && idxQ == '0);

endmodule

// File: rtl/lcd_seq_dp.sv
module lcd_seq_dp
  import lcd_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [1:0]         rotSel,
  input  biasCfg_t           cfgIn,
  input  logic [COORD_W-1:0] xIn,
  input  logic [COORD_W-1:0] yIn,
  output logic [7:0]         byteOut,
  output logic               cmdFlag
);

  seqJob_t            jobQ;
  logic [1:0]         rotQ;
  biasCfg_t           cfgQ;
  logic [COORD_W-1:0] xQ;
  logic [COORD_W-1:0] yQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      jobQ <= JOB_INIT;
      rotQ <= '0;
      cfgQ <= '0;
      xQ   <= '0;
      yQ   <= '0;
    end else if (strobe.load) begin
      jobQ <= strobe.job;
      rotQ <= rotSel;
      cfgQ <= cfgIn;
      xQ   <= xIn;
      yQ   <= yIn;
    end
  end

  // rotation decode: bit 0 marks the quarter turns
  logic       pageFirst;
  logic       mirrorX;
  logic       mirrorY;
  logic [7:0] colW;
  logic [7:0] rowW;

  always_comb begin
    pageFirst = rotQ[0];
    mirrorY   = rotQ[1];
    mirrorX   = (rotQ == 2'd0) || (rotQ == 2'd3);
    colW      = 8'(pageFirst ? yQ : xQ);
    rowW      = 8'(pageFirst ? xQ : yQ);
  end

  logic [7:0] initByte;
  logic [7:0] modeByte;
  logic [7:0] winByte;

  always_comb begin
    case (strobe.idx)
      4'd0:    initByte = 8'hE2;
      4'd1:    initByte = 8'hE8 | {6'd0, cfgQ.ratio};
      4'd2:    initByte = 8'h81;
      4'd3:    initByte = {cfgQ.gain, cfgQ.pot};
      4'd4:    initByte = 8'h24 | {6'd0, cfgQ.temp};
      4'd5:    initByte = 8'h28 | {6'd0, cfgQ.load};
      4'd6:    initByte = 8'h2C | {6'd0, cfgQ.pump};
      4'd7:    initByte = 8'hA7;
      4'd8:    initByte = 8'hD2;
      default: initByte = 8'hAF;
    endcase
  end

  always_comb begin
    if (strobe.idx == '0) modeByte = 8'h88 | {6'd0, pageFirst, 1'b1};
    else                  modeByte = 8'hC0 | {5'd0, mirrorY, mirrorX, 1'b0};
  end

  always_comb begin
    case (strobe.idx)
      4'd0:    winByte = {4'h0, colW[3:0]};
      4'd1:    winByte = 8'h10 | (colW >> 4);
      4'd2:    winByte = {4'h6, rowW[4:1]};
      default: winByte = 8'h70 | (rowW >> 5);
    endcase
  end

  always_comb begin
    case (jobQ)
      JOB_INIT:    byteOut = initByte;
      JOB_BLANK:   byteOut = 8'hA8;
      JOB_UNBLANK: byteOut = 8'hAF;
      JOB_MODE:    byteOut = modeByte;
      default:     byteOut = winByte;
    endcase
  end

  assign cmdFlag = 1'b0;

  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.active && !strobe.load |=> $stable(rotQ) && $stable(cfgQ)
                                      && $stable(xQ) && $stable(yQ));

  // R1
  init_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && strobe.job == JOB_INIT |=> byteOut == 8'hE2);

endmodule

// File: rtl/lcd_cmd_seq.sv
module lcd_cmd_seq
  import lcd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       initReq,
  input  logic       blankReq,
  input  logic       unblankReq,
  input  logic       modeReq,
  input  logic       windowReq,
  input  logic [1:0] rotSel,
  input  logic [1:0] ratioIn,
  input  logic [1:0] gainIn,
  input  logic [5:0] potIn,
  input  logic [1:0] tempIn,
  input  logic [1:0] loadIn,
  input  logic [1:0] pumpIn,
  input  logic [7:0] xStart,
  input  logic [7:0] yStart,
  output logic [7:0] outData,
  output logic       outValid,
  input  logic       outReady,
  output logic       outIsData,
  output logic       busy
);

  ctrlStrobe_t strobe;
  biasCfg_t    cfg;

  assign cfg = '{ratio: ratioIn, gain: gainIn, pot: potIn,
                 temp: tempIn, load: loadIn, pump: pumpIn};

  lcd_seq_ctrl ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .initReq    (initReq),
    .blankReq   (blankReq),
    .unblankReq (unblankReq),
    .modeReq    (modeReq),
    .windowReq  (windowReq),
    .outReady   (outReady),
    .strobe     (strobe),
    .outValid   (outValid),
    .busy       (busy)
  );

  lcd_seq_dp dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rotSel  (rotSel),
    .cfgIn   (cfg),
    .xIn     (COORD_W'(xStart)),
    .yIn     (COORD_W'(yStart)),
    .byteOut (outData),
    .cmdFlag (outIsData)
  );

  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

  // R12
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |-> !outValid && !busy);

endmodule

// File: tb/tb_lcd_cmd_seq.sv
module tb_lcd_cmd_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initReq = 0, blankReq = 0, unblankReq = 0, modeReq = 0, windowReq = 0;
  logic [1:0] rotSel = 0, ratioIn = 0, gainIn = 0, tempIn = 0, loadIn = 0, pumpIn = 0;
  logic [5:0] potIn = 0;
  logic [7:0] xStart = 0, yStart = 0;
  logic [7:0] outData;
  logic outValid, outIsData, busy;
  logic outReady = 1'b1;

  always #2 clk = ~clk;

  lcd_cmd_seq dut (.*);

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  typedef struct packed {
    logic [2:0]      code;   // 0 init,1 blank,2 unblank,3 mode,4 window
    logic [1:0]      rot;
    logic [1:0]      ratio;
    logic [1:0]      gain;
    logic [5:0]      pot;
    logic [1:0]      temp;
    logic [1:0]      load;
    logic [1:0]      pump;
    logic [7:0]      x;
    logic [7:0]      y;
    logic [3:0]      n;
    logic [0:9][7:0] b;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 2'd0, 2'd2, 2'd3, 6'd16, 2'd0, 2'd1, 2'd3, 8'h00, 8'h00, 4'd10,
      '{8'hE2, 8'hEA, 8'h81, 8'hD0, 8'h24, 8'h29, 8'h2F, 8'hA7, 8'hD2, 8'hAF}},
    '{3'd0, 2'd0, 2'd1, 2'd0, 6'd63, 2'd3, 2'd0, 2'd1, 8'h00, 8'h00, 4'd10,
      '{8'hE2, 8'hE9, 8'h81, 8'h3F, 8'h27, 8'h28, 8'h2D, 8'hA7, 8'hD2, 8'hAF}},
    '{3'd1, 2'd0, 2'd0, 2'd0, 6'd0, 2'd0, 2'd0, 2'd0, 8'h00, 8'h00, 4'd1,
      '{8'hA8, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}},
    '{3'd2, 2'd0, 2'd0, 2'd0, 6'd0, 2'd0, 2'd0, 2'd0, 8'h00, 8'h00, 4'd1,
      '{8'hAF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}},
    '{3'd3, 2'd0, 2'd0, 2'd0, 6'd0, 2'd0, 2'd0, 2'd0, 8'h00, 8'h00, 4'd2,
      '{8'h89, 8'hC2, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}},
    '{3'd3, 2'd1, 2'd0, 2'd0, 6'd0, 2'd0, 2'd0, 2'd0, 8'h00, 8'h00, 4'd2,
      '{8'h8B, 8'hC0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}},
    '{3'd3, 2'd2, 2'd0, 2'd0, 6'd0, 2'd0, 2'd0, 2'd0, 8'h00, 8'h00, 4'd2,
      '{8'h89, 8'hC4, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}},
    '{3'd3, 2'd3, 2'd0, 2'd0, 6'd0, 2'd0, 2'd0, 2'd0, 8'h00, 8'h00, 4'd2,
      '{8'h8B, 8'hC6, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}},
    '{3'd4, 2'd0, 2'd0, 2'd0, 6'd0, 2'd0, 2'd0, 2'd0, 8'hA5, 8'h9E, 4'd4,
      '{8'h05, 8'h1A, 8'h6F, 8'h74, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}},
    '{3'd4, 2'd1, 2'd0, 2'd0, 6'd0, 2'd0, 2'd0, 2'd0, 8'hA5, 8'h9E, 4'd4,
      '{8'h0E, 8'h19, 8'h62, 8'h75, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}},
    '{3'd4, 2'd2, 2'd0, 2'd0, 6'd0, 2'd0, 2'd0, 2'd0, 8'h00, 8'h01, 4'd4,
      '{8'h00, 8'h10, 8'h60, 8'h70, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}},
    '{3'd4, 2'd3, 2'd0, 2'd0, 6'd0, 2'd0, 2'd0, 2'd0, 8'hEF, 8'h9F, 4'd4,
      '{8'h0F, 8'h19, 8'h67, 8'h77, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic applyVec(input vec_t v);
    rotSel = v.rot; ratioIn = v.ratio; gainIn = v.gain; potIn = v.pot;
    tempIn = v.temp; loadIn = v.load; pumpIn = v.pump;
    xStart = v.x; yStart = v.y;
  endtask

  task automatic setReq(input logic [2:0] code, input logic val);
    case (code)
      3'd0: initReq = val;
      3'd1: blankReq = val;
      3'd2: unblankReq = val;
      3'd3: modeReq = val;
      default: windowReq = val;
    endcase
  endtask

  // request pulsed for one cycle; returns at the negedge where byte 0 shows
  task automatic pulse(input logic [2:0] code);
    @(negedge clk); setReq(code, 1'b1);
    @(negedge clk); setReq(code, 1'b0);
  endtask

  // collect n bytes with ready high; then busy and valid must be low (R9)
  task automatic collect(input int n, input logic [0:9][7:0] exp, input string req);
    for (int k = 0; k < n; k++) begin
      for (int w = 0; w < 20 && !outValid; w++) @(negedge clk);
      chk(req, outData, exp[k]);
      chk("R7", {7'd0, outIsData}, 8'd0);
      @(negedge clk);
    end
    chk("R9", {6'd0, busy, outValid}, 8'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 50000) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    chk("R12", {6'd0, busy, outValid}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12", {6'd0, busy, outValid}, 8'd0);

    // table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      applyVec(VEC[i]);
      pulse(VEC[i].code);
      case (VEC[i].code)
        3'd0: collect(VEC[i].n, VEC[i].b, "R1");
        3'd1, 3'd2: collect(VEC[i].n, VEC[i].b, "R2");
        3'd3: collect(VEC[i].n, VEC[i].b, "R3_R4");
        default: collect(VEC[i].n, VEC[i].b, "R5_R6");
      endcase
    end

    // R8 backpressure, R10 input changes mid-sequence ignored
    applyVec(VEC[8]);
    outReady = 1'b0;
    pulse(3'd4);
    rotSel = 2'd3; xStart = 8'h11; yStart = 8'h22;
    for (int c = 0; c < 3; c++) begin
      chk("R8", {7'd0, outValid}, 8'd1);
      chk("R8", outData, 8'h05);
      @(negedge clk);
    end
    pulse(3'd1);   // R10 request while busy
    outReady = 1'b1;
    collect(4, VEC[8].b, "R10");
    repeat (3) begin
      chk("R10", {7'd0, outValid}, 8'd0);
      @(negedge clk);
    end

    // R11 simultaneous init and blank: init wins
    applyVec(VEC[0]);
    @(negedge clk); initReq = 1; blankReq = 1;
    @(negedge clk); initReq = 0; blankReq = 0;
    collect(10, VEC[0].b, "R11");

    // R11 blank beats window
    @(negedge clk); blankReq = 1; windowReq = 1;
    @(negedge clk); blankReq = 0; windowReq = 0;
    collect(1, VEC[2].b, "R11");

    // R11 unblank beats mode
    @(negedge clk); unblankReq = 1; modeReq = 1;
    @(negedge clk); unblankReq = 0; modeReq = 0;
    collect(1, VEC[3].b, "R11");

    // R11 mode beats window
    applyVec(VEC[5]);
    @(negedge clk); modeReq = 1; windowReq = 1;
    @(negedge clk); modeReq = 0; windowReq = 0;
    collect(2, VEC[5].b, "R11");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule